// File: doc/BRIEF.md
# MAC statistics counter bank

A set of Ethernet MAC statistics counters read and written through a simple register port. There are four counters:

- a transmitted-octets counter of `OCT_W` bits (48 by default), split across two 32-bit register addresses;
- a count of good transmitted frames;
- a count of good received frames;
- a count of errored received frames.

The MAC feeds the bank with one-cycle frame-completion pulses. A transmit pulse carries the frame's octet count, a good/bad flag and a flag marking a pause frame that the MAC generated on its own.

Every counter clears when software reads it and sticks at all ones instead of wrapping. An optional snapshot set (`SNAP_EN`) copies all live counters and clears them in the same clock edge, so software can read a coherent set while counting continues. Level control inputs do three test jobs: they steer reads to the snapshot set or the live counters, they unlock test writes, and they force every counter up by one.

The octet counter is wider than the data port. A read of its low half latches the upper bits into a holding register and clears the whole counter. The next read of the high address returns the latched bits, so the two halves always belong to the same value.

Top module: `mac_stat_bank`

## Requirements
- R1: After a synchronous active-low reset, every counter, every snapshot register, the high-half holding register and `reg_rdata` are zero.
- R2: Address map: 0 is octets bits 31:0, 1 is octets upper bits (zero-extended), 2 is good tx frames, 3 is good rx frames, 4 is errored rx frames, and 5 to 7 read as zero. A read with `reg_rd` high updates `reg_rdata` at the next clock edge. A live read of address 0, 2, 3 or 4 clears that counter at the same edge; a read of address 1 clears nothing.
- R3: A counter whose next value would exceed its width holds at all ones.
- R4: A `tx_done` pulse with `tx_ok`=1 adds `tx_octets` to the octet counter unless `tx_pause_auto`=1. The tx frame counter counts every `tx_done` with `tx_ok`=1, pause frames included.
- R5: An `rx_done` pulse increments the rx good (`rx_ok`=1) or rx errored (`rx_ok`=0) counter only while `rx_enable` is 1.
- R6: A read of address 0 latches the counter's upper `OCT_W-32` bits into a holding register. Address 1 returns that held value, unaffected by later counting.
- R7: When a clearing read and a counter increment fall in the same cycle, the read returns the old value and the counter restarts at that cycle's increment.
- R8: A one-cycle `ctrl_snap` pulse copies all four live counters into the snapshot set and clears the live counters at the same edge.
- R9: With `ctrl_rd_snap`=1, reads return snapshot values and clear neither the snapshot set nor the live counters. The snapshot set changes only on `ctrl_snap`.
- R10: `reg_wr` loads the addressed counter from `reg_wdata` only while `ctrl_wr_en`=1. Address 0 writes bits 31:0 and address 1 writes the upper bits. Otherwise writes are ignored.
- R11: Each cycle with `ctrl_test_inc`=1 adds one to every counter, whatever the value of `rx_enable`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctrl_snap | input | 1 | Snapshot-and-clear pulse |
| ctrl_rd_snap | input | 1 | 1: reads return the snapshot set |
| ctrl_wr_en | input | 1 | Unlocks test writes |
| ctrl_test_inc | input | 1 | Adds one to every counter per cycle |
| rx_enable | input | 1 | Gates receive event counting |
| tx_done | input | 1 | Transmit frame completion pulse |
| tx_ok | input | 1 | Transmitted frame was error free |
| tx_pause_auto | input | 1 | Frame was an automatically generated pause frame |
| tx_octets | input | LEN_W | Octets in the transmitted frame |
| rx_done | input | 1 | Receive frame completion pulse |
| rx_ok | input | 1 | Received frame was error free |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, registered |

## Verification
The bench builds the bank with `OCT_W`=40, `FRM_W`=16, `LEN_W`=12 and `SNAP_EN`=1. A 40-bit octet counter leaves an 8-bit upper half, so the bench can check the zero-extension and latching of the high address with small values. Test writes let it preload both the octet counter and a 16-bit frame counter a few counts below all ones, which brings saturation within a handful of frames. The 12-bit frame length lets the vector table cover the longest frame the port can carry.

// File: rtl/mac_stat_pkg.sv
// Package: mac_stat_pkg
// Register addresses and port widths shared by the statistics bank.
// Assumes a 32-bit register data port and a 3-bit word address.
package mac_stat_pkg;
    localparam int REG_W  = 32;
    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] ADDR_OCT_LO = 3'd0;
    localparam logic [ADDR_W-1:0] ADDR_OCT_HI = 3'd1;
    localparam logic [ADDR_W-1:0] ADDR_TX_FRM = 3'd2;
    localparam logic [ADDR_W-1:0] ADDR_RX_FRM = 3'd3;
    localparam logic [ADDR_W-1:0] ADDR_RX_ERR = 3'd4;

    localparam int NUM_FRM = 3;  // frame counters at ADDR_TX_FRM and up
endpackage

// File: rtl/mac_stat_ctr.sv
// Module: mac_stat_ctr
// One statistics counter of W bits. It supports a clear-on-read input, a
// saturating add of a multi-bit increment and a test write split into a
// low word (up to 32 bits) and a high word (bits above 32).
// Assumes INC_W <= W. When clr and inc meet in one cycle, the counter
// restarts from zero plus inc. A write overrides clear and increment.
module mac_stat_ctr #(
    parameter int W     = 32,
    parameter int INC_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [INC_W-1:0] inc,
    input  logic             wr_lo,
    input  logic             wr_hi,
    input  logic [31:0]      wdata,
    output logic [W-1:0]     cnt
);
    localparam int LO_W = (W > 32) ? 32 : W;
    localparam int HI_W = W - LO_W;
    localparam int SW   = W + 1;

    logic [W-1:0] base;
    logic [W:0]   sum;
    logic [W-1:0] sat_val;
    logic [W-1:0] wr_val;
    logic [W-1:0] nxt;

    // Starting point: zero on a clearing read, else the held count.
    always_comb base = clr ? '0 : cnt;

    // Add with one guard bit; a carry out pins the result at all ones.
    always_comb begin
        sum     = {1'b0, base} + SW'(inc);
        sat_val = sum[W] ? '1 : sum[W-1:0];
    end

    generate
        if (HI_W > 0) begin : g_split
            // Test write of either word of a counter wider than 32 bits.
            always_comb begin
                wr_val = cnt;
                if (wr_lo) wr_val[LO_W-1:0] = wdata[LO_W-1:0];
                if (wr_hi) wr_val[W-1:LO_W] = wdata[HI_W-1:0];
            end
        end else begin : g_flat
            logic unused_hi;
            // Test write of a counter that fits in one word.
            always_comb begin
                wr_val = cnt;
                if (wr_lo) wr_val = wdata[W-1:0];
            end
            assign unused_hi = wr_hi;
        end
    endgenerate

    // A write beats counting.
    always_comb nxt = (wr_lo | wr_hi) ? wr_val : sat_val;

    // Counter register.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt <= '0;
        else        cnt <= nxt;
    end
endmodule

// File: rtl/mac_stat_snap.sv
// Module: mac_stat_snap
// Snapshot register set over the concatenated live counters. It captures
// the whole vector on take and holds it until the next take. With EN=0
// there is no storage and the output is zero.
module mac_stat_snap #(
    parameter int W  = 8,
    parameter bit EN = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         take,
    input  logic [W-1:0] live,
    output logic [W-1:0] snap
);
    generate
        if (EN) begin : g_on
            // Capture all counters in one edge.
            always_ff @(posedge clk) begin
                if (!rst_n)    snap <= '0;
                else if (take) snap <= live;
            end
        end else begin : g_off
            logic unused_off;
            assign snap       = '0;
            assign unused_off = take ^ (^live);
        end
    endgenerate
endmodule

// File: rtl/mac_stat_rdmux.sv
// Module: mac_stat_rdmux
// Read-data path. It picks the addressed counter from the selected source
// (live or snapshot), registers it on reg_rd and latches the octet
// counter's upper bits on a low-half read.
// Assumes 32 < OCT_W <= 64 and FRM_W <= 32.
module mac_stat_rdmux
    import mac_stat_pkg::*;
#(
    parameter int OCT_W = 48,
    parameter int FRM_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd,
    input  logic [ADDR_W-1:0] addr,
    input  logic [OCT_W-1:0]  oct,
    input  logic [FRM_W-1:0]  txf,
    input  logic [FRM_W-1:0]  rxf,
    input  logic [FRM_W-1:0]  rxe,
    output logic [REG_W-1:0]  rdata,
    output logic [OCT_W-33:0] hold
);
    logic [REG_W-1:0] mux;

    // Address decode of the read word.
    always_comb begin
        case (addr)
            ADDR_OCT_LO: mux = oct[31:0];
            ADDR_OCT_HI: mux = REG_W'(hold);
            ADDR_TX_FRM: mux = REG_W'(txf);
            ADDR_RX_FRM: mux = REG_W'(rxf);
            ADDR_RX_ERR: mux = REG_W'(rxe);
            default:     mux = '0;
        endcase
    end

    // Register read data; a low-half read also latches the upper bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
            hold  <= '0;
        end else if (rd) begin
            rdata <= mux;
            if (addr == ADDR_OCT_LO) hold <= oct[OCT_W-1:32];
        end
    end
endmodule

// File: rtl/mac_stat_bank.sv
// Module: mac_stat_bank
// MAC statistics bank: a wide transmitted-octets counter and NUM_FRM frame
// counters. All are clear-on-read and saturating, with an optional snapshot
// set and test write and increment controls. Assumes 32 < OCT_W <= 64,
// FRM_W <= 32 and LEN_W < OCT_W. Event inputs are single-cycle pulses.
module mac_stat_bank
    import mac_stat_pkg::*;
#(
    parameter int OCT_W   = 48,
    parameter int FRM_W   = 32,
    parameter int LEN_W   = 14,
    parameter bit SNAP_EN = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_snap,
    input  logic              ctrl_rd_snap,
    input  logic              ctrl_wr_en,
    input  logic              ctrl_test_inc,
    input  logic              rx_enable,
    input  logic              tx_done,
    input  logic              tx_ok,
    input  logic              tx_pause_auto,
    input  logic [LEN_W-1:0]  tx_octets,
    input  logic              rx_done,
    input  logic              rx_ok,
    input  logic              reg_rd,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata
);
    localparam int OINC_W = LEN_W + 1;
    localparam int ALL_W  = OCT_W + NUM_FRM * FRM_W;

    logic                sel_snap, take, live_rd, wr_ok;
    logic                tx_good, rx_evt;
    logic [OINC_W-1:0]   oct_inc;
    logic                oct_clr, oct_wr_lo, oct_wr_hi;
    logic [OCT_W-1:0]    oct_cnt;
    logic [FRM_W-1:0]    frm_cnt [NUM_FRM];
    logic [1:0]          frm_inc [NUM_FRM];
    logic [NUM_FRM-1:0]  frm_clr, frm_wr;
    logic [ALL_W-1:0]    live_all, snap_all, src_all;
    logic [OCT_W-33:0]   hi_hold;

    // Control qualification; snapshot controls vanish when not built.
    always_comb begin
        sel_snap = SNAP_EN & ctrl_rd_snap;
        take     = SNAP_EN & ctrl_snap;
        live_rd  = reg_rd & ~sel_snap;
        wr_ok    = reg_wr & ctrl_wr_en;
    end

    // Event qualification and per-counter increment amounts.
    always_comb begin
        tx_good    = tx_done & tx_ok;
        rx_evt     = rx_done & rx_enable;
        oct_inc    = ((tx_good & ~tx_pause_auto) ? OINC_W'(tx_octets) : '0)
                   + OINC_W'(ctrl_test_inc);
        frm_inc[0] = 2'(tx_good) + 2'(ctrl_test_inc);
        frm_inc[1] = 2'(rx_evt & rx_ok) + 2'(ctrl_test_inc);
        frm_inc[2] = 2'(rx_evt & ~rx_ok) + 2'(ctrl_test_inc);
    end

    // Octet counter clear and write strobes.
    always_comb begin
        oct_clr   = take | (live_rd && reg_addr == ADDR_OCT_LO);
        oct_wr_lo = wr_ok && reg_addr == ADDR_OCT_LO;
        oct_wr_hi = wr_ok && reg_addr == ADDR_OCT_HI;
    end

    mac_stat_ctr #(.W(OCT_W), .INC_W(OINC_W)) u_oct (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (oct_clr),
        .inc   (oct_inc),
        .wr_lo (oct_wr_lo),
        .wr_hi (oct_wr_hi),
        .wdata (reg_wdata),
        .cnt   (oct_cnt)
    );

    generate
        for (genvar i = 0; i < NUM_FRM; i++) begin : g_frm
            localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_TX_FRM + ADDR_W'(i);
            assign frm_clr[i] = take | (live_rd && reg_addr == MY_ADDR);
            assign frm_wr[i]  = wr_ok && reg_addr == MY_ADDR;
            mac_stat_ctr #(.W(FRM_W), .INC_W(2)) u_ctr (
                .clk   (clk),
                .rst_n (rst_n),
                .clr   (frm_clr[i]),
                .inc   (frm_inc[i]),
                .wr_lo (frm_wr[i]),
                .wr_hi (1'b0),
                .wdata (reg_wdata),
                .cnt   (frm_cnt[i])
            );
        end
    endgenerate

    // Concatenated live view: rx errors, rx frames, tx frames, octets.
    always_comb live_all = {frm_cnt[2], frm_cnt[1], frm_cnt[0], oct_cnt};

    mac_stat_snap #(.W(ALL_W), .EN(SNAP_EN)) u_snap (
        .clk   (clk),
        .rst_n (rst_n),
        .take  (take),
        .live  (live_all),
        .snap  (snap_all)
    );

    // Source select for reads.
    always_comb src_all = sel_snap ? snap_all : live_all;

    mac_stat_rdmux #(.OCT_W(OCT_W), .FRM_W(FRM_W)) u_rd (
        .clk   (clk),
        .rst_n (rst_n),
        .rd    (reg_rd),
        .addr  (reg_addr),
        .oct   (src_all[OCT_W-1:0]),
        .txf   (src_all[OCT_W +: FRM_W]),
        .rxf   (src_all[OCT_W + FRM_W +: FRM_W]),
        .rxe   (src_all[OCT_W + 2*FRM_W +: FRM_W]),
        .rdata (reg_rdata),
        .hold  (hi_hold)
    );
endmodule

// File: rtl/mac_stat_bank_chk.sv
// Module: mac_stat_bank_chk
// Checker bound into mac_stat_bank. It watches the ports together with the
// live counter vector, the snapshot set and the high-half holding register.
module mac_stat_bank_chk #(
    parameter int OCT_W   = 48,
    parameter int FRM_W   = 32,
    parameter bit SNAP_EN = 1'b1
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     ctrl_snap,
    input logic                     ctrl_rd_snap,
    input logic                     ctrl_wr_en,
    input logic                     ctrl_test_inc,
    input logic                     rx_enable,
    input logic                     tx_done,
    input logic                     reg_rd,
    input logic                     reg_wr,
    input logic [2:0]               reg_addr,
    input logic [OCT_W+3*FRM_W-1:0] live_all,
    input logic [OCT_W+3*FRM_W-1:0] snap_all,
    input logic [OCT_W-33:0]        hold
);
    logic [FRM_W-1:0] txf, rxf, rxe;
    logic             wr_hit;

    always_comb begin
        txf    = live_all[OCT_W +: FRM_W];
        rxf    = live_all[OCT_W + FRM_W +: FRM_W];
        rxe    = live_all[OCT_W + 2*FRM_W +: FRM_W];
        wr_hit = reg_wr & ctrl_wr_en;
    end

    // R2: a quiet live read of tx frames leaves it at zero.
    p_clear_on_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == 3'd2 && !(SNAP_EN && ctrl_rd_snap) && !tx_done
         && !ctrl_test_inc && !wr_hit) |=> (txf == '0));

    // R3: a full counter does not wrap.
    p_no_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (txf == '1 && !(reg_rd && reg_addr == 3'd2) && !ctrl_snap && !wr_hit)
        |=> (txf == '1));

    // R5: receive counters hold while receive is disabled.
    p_rx_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_enable && !ctrl_test_inc && !ctrl_snap && !reg_rd && !wr_hit)
        |=> ($stable(rxf) && $stable(rxe)));

    // R6: the holding register changes only on a low-half read.
    p_hold_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_rd && reg_addr == 3'd0) |=> $stable(hold));

    // R10: without write enable and events, tx frames stays put.
    p_write_guard_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_wr_en && !ctrl_test_inc && !tx_done && !ctrl_snap && !reg_rd)
        |=> $stable(txf));

    generate
        if (SNAP_EN) begin : g_snap_chk
            // R8: the snapshot takes the live values of the pulse cycle.
            p_snap_copy_r8: assert property (@(posedge clk) disable iff (!rst_n)
                ctrl_snap |=> (snap_all == $past(live_all)));

            // R8: live tx frames is cleared by the snapshot pulse.
            p_snap_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
                (ctrl_snap && !tx_done && !ctrl_test_inc && !wr_hit)
                |=> (txf == '0));

            // R9: the snapshot set moves only on a snapshot pulse.
            p_snap_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
                !ctrl_snap |=> $stable(snap_all));
        end
    endgenerate
endmodule

bind mac_stat_bank mac_stat_bank_chk #(
    .OCT_W   (OCT_W),
    .FRM_W   (FRM_W),
    .SNAP_EN (SNAP_EN)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .ctrl_snap     (ctrl_snap),
    .ctrl_rd_snap  (ctrl_rd_snap),
    .ctrl_wr_en    (ctrl_wr_en),
    .ctrl_test_inc (ctrl_test_inc),
    .rx_enable     (rx_enable),
    .tx_done       (tx_done),
    .reg_rd        (reg_rd),
    .reg_wr        (reg_wr),
    .reg_addr      (reg_addr),
    .live_all      (live_all),
    .snap_all      (snap_all),
    .hold          (hi_hold)
);

// File: tb/test_mac_stat_bank.sv
// Bench for mac_stat_bank. A vector table of transmit frames comes first,
// then directed tests. Inputs are driven and outputs sampled at negedge.
module test_mac_stat_bank;
    localparam int OCT_W = 40;
    localparam int FRM_W = 16;
    localparam int LEN_W = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctrl_snap = 1'b0, ctrl_rd_snap = 1'b0, ctrl_wr_en = 1'b0;
    logic        ctrl_test_inc = 1'b0, rx_enable = 1'b0;
    logic        tx_done = 1'b0, tx_ok = 1'b0, tx_pause_auto = 1'b0;
    logic [LEN_W-1:0] tx_octets = '0;
    logic        rx_done = 1'b0, rx_ok = 1'b0;
    logic        reg_rd = 1'b0, reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;

    int nvec = 0;
    int nerr = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    mac_stat_bank #(
        .OCT_W(OCT_W), .FRM_W(FRM_W), .LEN_W(LEN_W), .SNAP_EN(1'b1)
    ) i_mac_stat_bank (
        .clk(clk), .rst_n(rst_n), .ctrl_snap(ctrl_snap),
        .ctrl_rd_snap(ctrl_rd_snap), .ctrl_wr_en(ctrl_wr_en),
        .ctrl_test_inc(ctrl_test_inc), .rx_enable(rx_enable),
        .tx_done(tx_done), .tx_ok(tx_ok), .tx_pause_auto(tx_pause_auto),
        .tx_octets(tx_octets), .rx_done(rx_done), .rx_ok(rx_ok),
        .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    // Vector: {exp_frm, exp_oct[11:0], pause, ok, len[11:0]}
    localparam logic [26:0] VEC [8] = '{
        {1'b1, 12'd64,   1'b0, 1'b1, 12'd64},
        {1'b1, 12'd1500, 1'b0, 1'b1, 12'd1500},
        {1'b1, 12'd0,    1'b1, 1'b1, 12'd64},
        {1'b0, 12'd0,    1'b0, 1'b0, 12'd200},
        {1'b1, 12'd4095, 1'b0, 1'b1, 12'd4095},
        {1'b1, 12'd0,    1'b0, 1'b1, 12'd0},
        {1'b1, 12'd0,    1'b1, 1'b1, 12'd512},
        {1'b1, 12'd9,    1'b0, 1'b1, 12'd9}
    };

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        nvec++;
        if (got !== exp) begin
            nerr++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        reg_rd = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd = 1'b0;
        d = reg_rdata;
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] v);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic tx(input logic [LEN_W-1:0] len, input logic ok, input logic pause);
        tx_done = 1'b1; tx_octets = len; tx_ok = ok; tx_pause_auto = pause;
        @(negedge clk);
        tx_done = 1'b0;
    endtask

    task automatic rx(input logic ok);
        rx_done = 1'b1; rx_ok = ok;
        @(negedge clk);
        rx_done = 1'b0;
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            nerr++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk("R1 rdata after reset", reg_rdata, 32'h0);
        for (int a = 0; a < 6; a++) begin
            rd(3'(a), d);
            chk("R1 counter after reset", d, 32'h0);
        end

        // Table walk: R4 octet and frame accounting, R6 high half stays zero.
        for (int i = 0; i < 8; i++) begin
            tx(VEC[i][11:0], VEC[i][12], VEC[i][13]);
            rd(3'd0, d); chk("R4 octets", d, 32'(VEC[i][25:14]));
            rd(3'd1, d); chk("R6 octets high", d, 32'h0);
            rd(3'd2, d); chk("R4 tx frames", d, 32'(VEC[i][26]));
        end

        // R2: clear on read, accumulated value first.
        tx(12'd100, 1'b1, 1'b0);
        tx(12'd50, 1'b1, 1'b0);
        rd(3'd0, d); chk("R2 octet sum", d, 32'd150);
        rd(3'd0, d); chk("R2 octet cleared", d, 32'd0);
        rd(3'd2, d); chk("R2 frame sum", d, 32'd2);
        rd(3'd2, d); chk("R2 frame cleared", d, 32'd0);
        rd(3'd6, d); chk("R2 unused address", d, 32'd0);

        // R10: writes ignored without enable, applied with it.
        wr(3'd2, 32'h55);
        rd(3'd2, d); chk("R10 write ignored", d, 32'd0);
        ctrl_wr_en = 1'b1;
        wr(3'd2, 32'h1234);
        ctrl_wr_en = 1'b0;
        rd(3'd2, d); chk("R10 write applied", d, 32'h1234);

        // R6: low read latches the high half; later counting doesn't leak in.
        ctrl_wr_en = 1'b1;
        wr(3'd0, 32'hFFFF_FFF0);
        wr(3'd1, 32'h12);
        ctrl_wr_en = 1'b0;
        tx(12'h20, 1'b1, 1'b0);
        rd(3'd0, d); chk("R6 low half carry", d, 32'h0000_0010);
        tx(12'd5, 1'b1, 1'b0);
        rd(3'd1, d); chk("R6 latched high half", d, 32'h13);
        rd(3'd0, d); chk("R6 cleared on low read", d, 32'd5);
        rd(3'd1, d); chk("R6 high after clear", d, 32'h0);
        rd(3'd2, d);

        // R3: saturation of octets and frames.
        ctrl_wr_en = 1'b1;
        wr(3'd0, 32'hFFFF_FFF0);
        wr(3'd1, 32'hFF);
        wr(3'd2, 32'hFFFE);
        ctrl_wr_en = 1'b0;
        tx(12'h100, 1'b1, 1'b0);
        tx(12'd1, 1'b1, 1'b0);
        rd(3'd0, d); chk("R3 octet low saturated", d, 32'hFFFF_FFFF);
        rd(3'd1, d); chk("R3 octet high saturated", d, 32'hFF);
        rd(3'd2, d); chk("R3 frames saturated", d, 32'hFFFF);
        rd(3'd0, d); chk("R3 cleared after saturation", d, 32'd0);

        // R5: receive gating.
        rx_enable = 1'b0;
        rx(1'b1); rx(1'b0);
        rd(3'd3, d); chk("R5 rx good gated", d, 32'd0);
        rd(3'd4, d); chk("R5 rx error gated", d, 32'd0);
        rx_enable = 1'b1;
        rx(1'b1); rx(1'b1); rx(1'b0);
        rd(3'd3, d); chk("R5 rx good counted", d, 32'd2);
        rd(3'd4, d); chk("R5 rx error counted", d, 32'd1);

        // R7: read and increment in the same cycle.
        tx(12'd0, 1'b1, 1'b0); tx(12'd0, 1'b1, 1'b0); tx(12'd0, 1'b1, 1'b0);
        reg_rd = 1'b1; reg_addr = 3'd2;
        tx_done = 1'b1; tx_ok = 1'b1; tx_pause_auto = 1'b0; tx_octets = '0;
        @(negedge clk);
        reg_rd = 1'b0; tx_done = 1'b0;
        chk("R7 old value returned", reg_rdata, 32'd3);
        rd(3'd2, d); chk("R7 increment kept", d, 32'd1);
        rd(3'd0, d);

        // R11: test increment hits all counters, even with rx disabled.
        rx_enable = 1'b0;
        ctrl_test_inc = 1'b1;
        @(negedge clk);
        ctrl_test_inc = 1'b0;
        rd(3'd0, d); chk("R11 octets", d, 32'd1);
        rd(3'd1, d); chk("R11 octets high", d, 32'd0);
        rd(3'd2, d); chk("R11 tx frames", d, 32'd1);
        rd(3'd3, d); chk("R11 rx frames", d, 32'd1);
        rd(3'd4, d); chk("R11 rx errors", d, 32'd1);

        // R8 and R9: snapshot copy, clear and selectable reads.
        rx_enable = 1'b1;
        tx(12'd10, 1'b1, 1'b0);
        rx(1'b1);
        ctrl_snap = 1'b1;
        @(negedge clk);
        ctrl_snap = 1'b0;
        tx(12'd7, 1'b1, 1'b0);
        ctrl_rd_snap = 1'b1;
        rd(3'd0, d); chk("R9 snapshot octets", d, 32'd10);
        rd(3'd1, d); chk("R9 snapshot octets high", d, 32'd0);
        rd(3'd2, d); chk("R9 snapshot tx frames", d, 32'd1);
        rd(3'd3, d); chk("R9 snapshot rx frames", d, 32'd1);
        rd(3'd0, d); chk("R9 snapshot not cleared", d, 32'd10);
        ctrl_rd_snap = 1'b0;
        rd(3'd0, d); chk("R8 live after snapshot", d, 32'd7);
        rd(3'd2, d); chk("R9 live untouched by snapshot reads", d, 32'd1);
        rd(3'd3, d); chk("R8 live rx cleared", d, 32'd0);
        ctrl_rd_snap = 1'b1;
        rd(3'd2, d); chk("R9 snapshot survives live reads", d, 32'd1);
        ctrl_rd_snap = 1'b0;

        // R1: mid-run reset clears live and snapshot state.
        tx(12'd33, 1'b1, 1'b0);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        rd(3'd0, d); chk("R1 live after reset", d, 32'd0);
        ctrl_rd_snap = 1'b1;
        rd(3'd2, d); chk("R1 snapshot after reset", d, 32'd0);
        ctrl_rd_snap = 1'b0;

        done = 1'b1;
        summary();
        $finish;
    end
endmodule